// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides one integer by another over many clock cycles, one quotient bit per cycle, using a single divisor-width subtractor. It works on a double-width working register. The low half of that register gathers quotient bits as the register shifts left. The high half holds the partial remainder. The subtraction is tried against the high half. If the subtraction would go negative, the old value is kept, which is the restoring step. When all iterations are done, the high half is shifted right by one place to give the true remainder.

Operands enter through a valid/ready input. `in_ready` is high only while the divider is idle. A pair is taken on a rising edge where `in_valid` and `in_ready` are both high. While a division is running, `in_ready` stays low and `in_valid` is ignored. A source that wants to present operands must therefore hold them, with `in_valid` high, until it sees `in_ready`. The output side has no back-pressure. A one-cycle `done` pulse marks the moment that `lo` (quotient) and `hi` (remainder) have been updated. Both values then hold until the next `done`.

With `is_signed` high, the divider takes the magnitude of each operand and divides those magnitudes. It then negates the quotient when the operand signs differ and gives the remainder the sign of the dividend. With `is_signed` low, the operands are plain unsigned values and no sign correction is applied.

Top module: `seq_divider`

## Requirements
- R1: In unsigned mode with a nonzero divisor, `lo` equals dividend / divisor rounded down, and `hi` equals dividend mod divisor. For example, 7 / 2 gives `lo`=3 and `hi`=1, and 5 / 9 gives `lo`=0 and `hi`=5.
- R2: In signed mode (two's complement) with a nonzero divisor, `lo` is the quotient truncated toward zero. It is negative exactly when the operand signs differ and the quotient is nonzero: -7 / 2 gives -3, -7 / -2 gives 3, and 7 / -2 gives -3.
- R3: In signed mode with a nonzero divisor, a nonzero `hi` has the sign of the dividend and a magnitude below the magnitude of the divisor: -7 / 2 gives -1, -7 / -2 gives -1, and 7 / -2 gives 1.
- R4: With a zero divisor, in either mode, the division completes normally. `lo` is all ones and `hi` equals the dividend unchanged.
- R5: `done` rises on the (WIDTH+1)th rising edge after the edge that accepts the operands, and it stays high for exactly one cycle.
- R6: `in_ready` is low from the accepting edge until `done` is asserted, and it is high while `done` is high. A pulse of `in_valid` with other operands during that time is ignored and does not change the result that follows.
- R7: `hi` and `lo` change only on the edge that raises `done`, and they hold their value in all other cycles.
- R8: After reset, `in_ready`=1, `done`=0, `hi`=0 and `lo`=0.
- R9: In signed mode, the most negative value divided by -1 wraps to `lo`=0x8000_0000 with `hi`=0.
- R10: In unsigned mode, no sign correction is applied: 0xFFFF_FFF9 / 2 gives `lo`=0x7FFF_FFFC and `hi`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair presented |
| in_ready | output | 1 | Divider idle, operands can be accepted |
| dividend | input | WIDTH | Dividend |
| divisor | input | WIDTH | Divisor |
| is_signed | input | 1 | 1: two's complement operands, 0: unsigned operands |
| done | output | 1 | One-cycle pulse, result updated |
| hi | output | WIDTH | Remainder |
| lo | output | WIDTH | Quotient |

## Verification
The hardest case to reach from the ports is an operand pair offered while a division is already running. The divider must refuse it, and the refusal must leave the running result untouched. To create this case, the stimulus raises `in_valid` with different operands for several cycles right after an accepted pair, while `in_ready` is still low. The scoreboard then expects only the first result. Values that stress the subtract-or-restore decision at the top bit are also driven: divisors with the top bit set, the most negative dividend with -1, and a zero divisor, which makes every trial subtraction succeed.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FIX
  } div_state_t;
endpackage

// File: rtl/div_sign_prep.sv
// Converts the operands to magnitudes and reports their signs.
module div_sign_prep #(
  parameter int W = 32
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         use_sign,
  output logic [W-1:0] mag_a,
  output logic [W-1:0] mag_b,
  output logic         neg_a,
  output logic         neg_b
);
  always_comb begin
    neg_a = use_sign & op_a[W-1];
    neg_b = use_sign & op_b[W-1];
    mag_a = neg_a ? (~op_a + 1'b1) : op_a;
    mag_b = neg_b ? (~op_b + 1'b1) : op_b;
  end
endmodule

// File: rtl/div_core.sv
// Restoring divider core: shift first, then try to subtract from the upper half.
module div_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] dvd_mag,
  input  logic [W-1:0] dsr_mag,
  output logic         busy,
  output logic         finish,
  output logic [W-1:0] quo_mag,
  output logic [W-1:0] rem_mag
);
  import div_pkg::*;

  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam int AW = 2 * W + 1;

  div_state_t      state;
  logic [AW-1:0]   acc;
  logic [W-1:0]    dsr;
  logic [CW-1:0]   cnt;
  logic            fits;
  logic [W-1:0]    diff;
  logic [AW-1:0]   acc_nxt;

  always_comb begin
    fits = acc[2*W] | (acc[2*W-1:W] >= dsr);
    diff = acc[2*W-1:W] - dsr;
    if (fits) acc_nxt = {diff, acc[W-1:0], 1'b1};
    else      acc_nxt = {acc[2*W-1:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      acc   <= '0;
      dsr   <= '0;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (load) begin
          acc   <= {{W{1'b0}}, dvd_mag, 1'b0};
          dsr   <= dsr_mag;
          cnt   <= '0;
          state <= ST_RUN;
        end
        ST_RUN: begin
          acc <= acc_nxt;
          cnt <= cnt + 1'b1;
          if (cnt == CW'(W - 1)) state <= ST_FIX;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy    = (state != ST_IDLE);
  assign finish  = (state == ST_FIX);
  assign quo_mag = acc[W-1:0];
  assign rem_mag = acc[2*W:W+1];
endmodule

// File: rtl/div_sign_fix.sv
// Applies the sign rules and the zero-divisor result.
module div_sign_fix #(
  parameter int W = 32
) (
  input  logic [W-1:0] quo_mag,
  input  logic [W-1:0] rem_mag,
  input  logic         flip_quo,
  input  logic         flip_rem,
  input  logic         zero_dsr,
  input  logic [W-1:0] raw_dvd,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  always_comb begin
    if (zero_dsr) begin
      quo = '1;
      rem = raw_dvd;
    end else begin
      quo = flip_quo ? (~quo_mag + 1'b1) : quo_mag;
      rem = flip_rem ? (~rem_mag + 1'b1) : rem_mag;
    end
  end
endmodule

// File: rtl/seq_divider.sv
module seq_divider #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  input  logic             is_signed,
  output logic             done,
  output logic [WIDTH-1:0] hi,
  output logic [WIDTH-1:0] lo
);
  logic [WIDTH-1:0] mag_a, mag_b, quo_mag, rem_mag, quo, rem;
  logic             neg_a, neg_b, busy, finish, accept;
  logic             flip_quo_q, flip_rem_q, zero_dsr_q, signed_q;
  logic [WIDTH-1:0] dvd_q;

  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;

  div_sign_prep #(.W(WIDTH)) u_prep (
    .op_a(dividend), .op_b(divisor), .use_sign(is_signed),
    .mag_a(mag_a), .mag_b(mag_b), .neg_a(neg_a), .neg_b(neg_b)
  );

  div_core #(.W(WIDTH)) u_core (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .dvd_mag(mag_a), .dsr_mag(mag_b),
    .busy(busy), .finish(finish), .quo_mag(quo_mag), .rem_mag(rem_mag)
  );

  div_sign_fix #(.W(WIDTH)) u_fix (
    .quo_mag(quo_mag), .rem_mag(rem_mag),
    .flip_quo(flip_quo_q), .flip_rem(flip_rem_q),
    .zero_dsr(zero_dsr_q), .raw_dvd(dvd_q),
    .quo(quo), .rem(rem)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flip_quo_q <= 1'b0;
      flip_rem_q <= 1'b0;
      zero_dsr_q <= 1'b0;
      signed_q   <= 1'b0;
      dvd_q      <= '0;
      done       <= 1'b0;
      hi         <= '0;
      lo         <= '0;
    end else begin
      done <= finish;
      if (accept) begin
        flip_quo_q <= neg_a ^ neg_b;
        flip_rem_q <= neg_a;
        zero_dsr_q <= (divisor == '0);
        signed_q   <= is_signed;
        dvd_q      <= dividend;
      end
      if (finish) begin
        hi <= rem;
        lo <= quo;
      end
    end
  end
endmodule

// File: rtl/seq_divider_chk.sv
module seq_divider_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         done,
  input logic [W-1:0] hi,
  input logic [W-1:0] lo,
  input logic         zero_dsr_q,
  input logic         flip_rem_q,
  input logic         signed_q
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R5
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_ready) |=> !in_ready); // R6
  AST_READY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n) done |-> in_ready); // R6
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !done |-> ($stable(hi) && $stable(lo))); // R7
  AST_ZERO_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n) (done && zero_dsr_q) |-> (lo == '1)); // R4
  AST_REM_SIGN: assert property (@(posedge clk) disable iff (!rst_n) (done && signed_q && !zero_dsr_q && hi != '0) |-> (hi[W-1] == flip_rem_q)); // R3
endmodule

bind seq_divider seq_divider_chk #(.W(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .done(done), .hi(hi), .lo(lo), .zero_dsr_q(zero_dsr_q),
  .flip_rem_q(flip_rem_q), .signed_q(signed_q)
);

// File: tb/seq_divider_test.sv
module seq_divider_test;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         is_signed = 1'b0;
  logic         done;
  logic [W-1:0] hi, lo;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  typedef struct {
    logic [W-1:0] exp_lo;
    logic [W-1:0] exp_hi;
    int           acc_cyc;
    string        tag;
  } item_t;
  item_t sb[$];

  seq_divider #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .dividend(dividend), .divisor(divisor), .is_signed(is_signed),
    .done(done), .hi(hi), .lo(lo)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model from the requirements.
  function automatic void model(input logic [W-1:0] a, input logic [W-1:0] b, input bit sg,
                                output logic [W-1:0] q, output logic [W-1:0] r);
    longint sa, sb2, sq, sr;
    if (b == '0) begin
      q = '1; r = a;
    end else if (sg) begin
      sa = longint'($signed(a)); sb2 = longint'($signed(b));
      sq = sa / sb2; sr = sa % sb2;
      q = sq[W-1:0]; r = sr[W-1:0];
    end else begin
      q = a / b; r = a % b;
    end
  endfunction

  task automatic push(input logic [W-1:0] a, input logic [W-1:0] b, input bit sg, input string tag);
    item_t it;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    dividend = a; divisor = b; is_signed = sg; in_valid = 1'b1;
    model(a, b, sg, it.exp_lo, it.exp_hi);
    it.tag = tag;
    @(posedge clk);
    #1;
    it.acc_cyc = cyc;
    sb.push_back(it);
    in_valid = 1'b0;
  endtask

  // Monitor
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        if (sb.size() == 0) begin
          check(1'b0, "R5 unexpected done", 64'(done), 64'(0));
        end else begin
          item_t it;
          it = sb.pop_front();
          check(lo == it.exp_lo, {it.tag, " quotient"}, 64'(lo), 64'(it.exp_lo));
          check(hi == it.exp_hi, {it.tag, " remainder"}, 64'(hi), 64'(it.exp_hi));
          check(cyc - it.acc_cyc == W + 1, "R5 latency", 64'(cyc - it.acc_cyc), 64'(W + 1));
          check(in_ready == 1'b1, "R6 ready during done", 64'(in_ready), 64'(1));
          @(negedge clk);
          check(done == 1'b0, "R5 done width", 64'(done), 64'(0));
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", 64'(0), 64'(1));
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] hold_lo, hold_hi;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(in_ready == 1'b1 && done == 1'b0 && hi == '0 && lo == '0, "R8 reset state",
          {in_ready, done, hi[29:0], lo}, 64'h8000_0000_0000_0000);
    rst_n = 1'b1;

    push(32'd7, 32'd2, 1'b0, "R1 7/2");
    push(32'd5, 32'd9, 1'b0, "R1 5/9");
    push(32'hDEAD_BEEF, 32'h0000_1234, 1'b0, "R1 large");
    push(32'hFFFF_FFFF, 32'h8000_0001, 1'b0, "R1 top-bit divisor");
    push(-32'sd7, 32'd2, 1'b1, "R2 R3 -7/2");
    push(-32'sd7, -32'sd2, 1'b1, "R2 R3 -7/-2");
    push(32'd7, -32'sd2, 1'b1, "R2 R3 7/-2");
    push(-32'sd1000003, 32'd97, 1'b1, "R2 R3 neg/pos");
    push(32'd123, 32'd0, 1'b0, "R4 unsigned zero divisor");
    push(-32'sd5, 32'd0, 1'b1, "R4 signed zero divisor");
    push(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, "R9 min/-1");
    push(32'hFFFF_FFF9, 32'd2, 1'b0, "R10 unsigned no fix");

    // R6: offer other operands while busy; they must be ignored.
    push(32'd100, 32'd7, 1'b0, "R6 first result kept");
    @(negedge clk);
    dividend = 32'd999; divisor = 32'd1; is_signed = 1'b1; in_valid = 1'b1;
    for (int i = 0; i < 10; i++) begin
      check(in_ready == 1'b0, "R6 ready low while busy", 64'(in_ready), 64'(0));
      @(negedge clk);
    end
    in_valid = 1'b0;

    while (sb.size() != 0) @(negedge clk);
    // R7: result holds after done.
    @(negedge clk);
    hold_lo = lo; hold_hi = hi;
    repeat (6) @(negedge clk);
    check(lo == hold_lo && hi == hold_hi, "R7 hold", {hi, lo}, {hold_hi, hold_lo});
    check(lo == 32'd14 && hi == 32'd2, "R6 ignored offer", {hi, lo}, {32'd2, 32'd14});
    check(in_ready == 1'b1, "R6 idle after work", 64'(in_ready), 64'(1));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule